// File: doc/BRIEF.md
# Byte Stream Output Sequencer

The sequencer moves a buffer of bytes onto a parallel output bus at a rate of one byte per clock. It fetches each byte over a simple ready/data interface from a buffer. The byte count for the buffer is sampled when a run begins. Two side-band pins go with the bus, and their meaning depends on the selected mode.

In streaming mode, side pin A gives a lead-in pulse, and side pin B frames the bytes as a valid window. The window closes after the last byte, when a bus error is reported, or when the run condition is removed. In message mode, pin A marks the start of a message and pin B marks its end. When the message ends, the block sets a buffer-empty flag, raises a held interrupt, clears its own enable bit and stops until software writes the enable bit again.

Top module: `bytestream_seq`

## Requirements
- R1: While reset is low and after its release, `out_data` is zero, `side_a`, `side_b`, `irq`, `buf_empty` and `enable_o` are low.
- R2: A streaming run (`mode_msg` = 0) starts only when the enable bit and `sync_en` are both high; with `sync_en` low nothing appears on `out_data`, `side_a` or `side_b`.
- R3: A streaming run begins with one lead cycle in which `side_a` is high for exactly one clock, `side_b` rises and `out_data` is zero; the first byte follows in the next cycle.
- R4: Buffer bytes appear on `out_data` in buffer order, one per cycle in which `fetch_req` and `fetch_rdy` are both high, registered to the following cycle; a cycle with `fetch_rdy` low shows zero and delays the rest, while `side_b` stays high in streaming mode.
- R5: In streaming mode `side_b` falls and `out_data` is zero in the cycle right after the last byte.
- R6: A `bus_err` high during a streaming run (lead cycle included) drops `side_b` and zeroes `out_data` in the next cycle; no further bytes of that buffer are sent.
- R7: A streaming run sends one buffer; another run needs the run condition (enable, `sync_en`, streaming mode) to go low and high again.
- R8: In message mode, writing the enable bit high starts a message: `side_a` is a one-cycle start pulse in the cycle before the first byte, `side_b` stays low while bytes are sent, and `sync_en` and `bus_err` have no effect.
- R9: In message mode, the cycle after the last byte shows a one-cycle end pulse on `side_b` with `out_data` zero; `buf_empty` and `irq` go high and `enable_o` goes low at that same edge.
- R10: After a message ends, the block stays idle while `mode_msg` stays high, until the enable bit is written high again.
- R11: `irq` stays high until `irq_ack` is sampled high and is low in the next cycle; `buf_empty` clears at the edge that starts the next message.
- R12: A byte count of zero gives, in streaming mode, a lead cycle followed at once by `side_b` low; in message mode, a start pulse followed at once by an end pulse, with no bytes.
- R13: `out_data` is zero in every cycle in which no buffer byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_msg | input | 1 | 0 selects streaming mode, 1 selects message mode |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| sync_en | input | 1 | Stream-sync bit; must be high for streaming |
| bus_err | input | 1 | Bus error; aborts a streaming valid window |
| byte_count | input | CNT_W (16) | Bytes in the buffer, sampled when a run starts |
| fetch_req | output | 1 | Block wants the next buffer byte |
| fetch_rdy | input | 1 | Buffer presents a byte this cycle |
| fetch_data | input | DATA_W (8) | Byte from the buffer |
| out_data | output | DATA_W (8) | Output byte bus |
| side_a | output | 1 | Streaming lead pulse / message start pulse |
| side_b | output | 1 | Streaming valid window / message end pulse |
| buf_empty | output | 1 | Set when a message has been fully sent |
| irq | output | 1 | Message-complete interrupt |
| irq_ack | input | 1 | Clears `irq` |
| enable_o | output | 1 | Current state of the enable bit |

## Verification
A cycle-by-cycle scoreboard predicts the bus and both side pins for each run. Streaming runs cover a ready buffer, a buffer with gaps, an error in the middle of a buffer and a zero count. Together these separate the lead-cycle timing, the stall handling, the window close at the count and the abort path. Message runs hold `sync_en` low and pulse `bus_err`, which shows that both are ignored there, and a run with `sync_en` low in streaming mode shows that nothing starts. After each run the bench watches the idle cycles, then checks the flag, the interrupt hold and acknowledge, and the enable self-clear.

// File: rtl/bss_pkg.sv
package bss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } bss_state_e;
endpackage

// File: rtl/bss_counter.sv
module bss_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("bss_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= load_val;
      end else if (dec && (rem_q != '0)) begin
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign zero_o = (rem_q == '0);

   // R4: the sequencer never consumes a byte the buffer does not hold
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (rem_q != '0));
endmodule

// File: rtl/bss_ctrl_regs.sv
module bss_ctrl_regs #(
   parameter bit IRQ_HOLD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic msg_start,
   input  logic msg_done,
   input  logic irq_ack,
   output logic en_o,
   output logic irq_o,
   output logic empty_o
);
   logic en_q, irq_q, empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         empty_q <= 1'b0;
      end else begin
         if (en_wr)         en_q <= en_wdata;
         else if (msg_done) en_q <= 1'b0;
         if (msg_done)       empty_q <= 1'b1;
         else if (msg_start) empty_q <= 1'b0;
      end
   end

   generate
      if (IRQ_HOLD) begin : g_irq_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        irq_q <= 1'b0;
            else if (msg_done) irq_q <= 1'b1;
            else if (irq_ack)  irq_q <= 1'b0;
         end
         // R11: interrupt held until acknowledged
         a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q && !irq_ack && !msg_done) |=> irq_q);
      end else begin : g_irq_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= msg_done;
         end
      end
   endgenerate

   assign en_o    = en_q;
   assign irq_o   = irq_q;
   assign empty_o = empty_q;

   // R9: interrupt and empty flag rise together at message end
   a_r9_irq_with_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> empty_q);
endmodule

// File: rtl/bss_fsm.sv
module bss_fsm
   import bss_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_msg,
   input  logic              en,
   input  logic              sync_en,
   input  logic              bus_err,
   input  logic              cnt_zero,
   input  logic              fetch_rdy,
   input  logic [DATA_W-1:0] fetch_data,
   output logic              cnt_load,
   output logic              cnt_dec,
   output logic              fetch_req,
   output logic              msg_start,
   output logic              msg_done,
   output logic [DATA_W-1:0] data_o,
   output logic              side_a_o,
   output logic              side_b_o
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("bss_fsm: DATA_W must be at least 1");
      end
   endgenerate

   bss_state_e        state;
   logic              mode_lat;
   logic [DATA_W-1:0] data_q;
   logic              a_q, b_q;
   logic              run_stream, go, abort;

   always_comb begin
      run_stream = en && sync_en && !mode_msg;
      go         = (state == ST_IDLE) && (mode_msg ? en : run_stream);
      abort      = (state == ST_SEND) && !mode_lat && (bus_err || !run_stream);
      fetch_req  = (state == ST_SEND) && !cnt_zero;
      cnt_dec    = fetch_req && fetch_rdy && !abort;
      cnt_load   = go;
      msg_start  = go && mode_msg;
      msg_done   = (state == ST_SEND) && mode_lat && cnt_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_lat <= 1'b0;
         data_q   <= '0;
         a_q      <= 1'b0;
         b_q      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               a_q    <= 1'b0;
               b_q    <= 1'b0;
               data_q <= '0;
               if (go) begin
                  state    <= ST_SEND;
                  mode_lat <= mode_msg;
                  a_q      <= 1'b1;
                  b_q      <= !mode_msg;
               end
            end
            ST_SEND: begin
               a_q <= 1'b0;
               if (abort) begin
                  state  <= ST_WAIT;
                  b_q    <= 1'b0;
                  data_q <= '0;
               end else if (cnt_zero) begin
                  data_q <= '0;
                  if (mode_lat) begin
                     b_q   <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     b_q   <= 1'b0;
                     state <= ST_WAIT;
                  end
               end else if (fetch_rdy) begin
                  data_q <= fetch_data;
               end else begin
                  data_q <= '0;
               end
            end
            ST_WAIT: begin
               a_q    <= 1'b0;
               b_q    <= 1'b0;
               data_q <= '0;
               if (!run_stream) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign data_o   = data_q;
   assign side_a_o = a_q;
   assign side_b_o = b_q;

   // R3 / R8: lead and start pulses are one clock wide
   a_r3_lead_single: assert property (@(posedge clk) disable iff (!rst_n)
      a_q |=> !a_q);
   // R13: the lead cycle carries no byte
   a_r13_lead_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      a_q |-> (data_q == '0));
   // R6: a bus error closes the streaming window in the next cycle
   a_r6_err_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SEND) && !mode_lat && bus_err) |=> (!b_q && (data_q == '0)));
   // R9: the message end marker is one clock wide
   a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_lat && b_q) |=> !b_q);
   // R4: streamed bytes appear only inside the valid window
   a_r4_data_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_lat && (data_q != '0)) |-> b_q);
   // R2: no run starts in streaming mode without the full run condition
   a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && !mode_msg && !(en && sync_en)) |=> !a_q);
endmodule

// File: rtl/bytestream_seq.sv
module bytestream_seq #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter bit IRQ_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_msg,
   input  logic              en_wr,
   input  logic              en_wdata,
   input  logic              sync_en,
   input  logic              bus_err,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              fetch_req,
   input  logic              fetch_rdy,
   input  logic [DATA_W-1:0] fetch_data,
   output logic [DATA_W-1:0] out_data,
   output logic              side_a,
   output logic              side_b,
   output logic              buf_empty,
   output logic              irq,
   input  logic              irq_ack,
   output logic              enable_o
);
   logic en_q, cnt_load, cnt_dec, cnt_zero, msg_start, msg_done;

   bss_ctrl_regs #(.IRQ_HOLD(IRQ_HOLD)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_wr     (en_wr),
      .en_wdata  (en_wdata),
      .msg_start (msg_start),
      .msg_done  (msg_done),
      .irq_ack   (irq_ack),
      .en_o      (en_q),
      .irq_o     (irq),
      .empty_o   (buf_empty)
   );

   bss_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (byte_count),
      .dec      (cnt_dec),
      .zero_o   (cnt_zero)
   );

   bss_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_msg   (mode_msg),
      .en         (en_q),
      .sync_en    (sync_en),
      .bus_err    (bus_err),
      .cnt_zero   (cnt_zero),
      .fetch_rdy  (fetch_rdy),
      .fetch_data (fetch_data),
      .cnt_load   (cnt_load),
      .cnt_dec    (cnt_dec),
      .fetch_req  (fetch_req),
      .msg_start  (msg_start),
      .msg_done   (msg_done),
      .data_o     (out_data),
      .side_a_o   (side_a),
      .side_b_o   (side_b)
   );

   assign enable_o = en_q;
endmodule

// File: tb/test_bytestream_seq.sv
`timescale 1ns/1ps
module test_bytestream_seq;
   typedef struct {
      logic [7:0] d;
      logic       a;
      logic       b;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_msg = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, sync_en = 1'b0;
   logic        bus_err = 1'b0, fetch_rdy = 1'b1, irq_ack = 1'b0;
   logic [15:0] byte_count = '0;
   logic        fetch_req, side_a, side_b, buf_empty, irq, enable_o;
   logic [7:0]  out_data, fetch_data;
   logic [7:0]  bmem [0:63];
   int          bidx = 0;
   int          nchk = 0, nfail = 0;
   exp_t        q[$];

   always #2.5 clk = ~clk;

   assign fetch_data = bmem[bidx];

   bytestream_seq i_bytestream_seq (
      .clk(clk), .rst_n(rst_n), .mode_msg(mode_msg), .en_wr(en_wr), .en_wdata(en_wdata),
      .sync_en(sync_en), .bus_err(bus_err), .byte_count(byte_count), .fetch_req(fetch_req),
      .fetch_rdy(fetch_rdy), .fetch_data(fetch_data), .out_data(out_data), .side_a(side_a),
      .side_b(side_b), .buf_empty(buf_empty), .irq(irq), .irq_ack(irq_ack), .enable_o(enable_o)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic void push(input logic [7:0] d, input logic a, input logic b, input string t);
      exp_t e;
      e.d = d; e.a = a; e.b = b; e.tag = t;
      q.push_back(e);
   endfunction

   // monitor: one expected item per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(out_data == e.d, e.tag, "out_data", int'(out_data), int'(e.d));
         chk(side_a == e.a, e.tag, "side_a", int'(side_a), int'(e.a));
         chk(side_b == e.b, e.tag, "side_b", int'(side_b), int'(e.b));
      end
   end

   // driver: starts one run and pushes the expected bus for every cycle
   task automatic run_buf(input bit msg, input int n, input logic [31:0] rdy_mask,
                          input int err_step, input string tag, input string idle_tag);
      int rem = n;
      int k = 0;
      int j = 0;
      bit fin = 0;
      @(negedge clk); #1;
      en_wr = 1'b1; en_wdata = 1'b1; mode_msg = msg; byte_count = 16'(n); bidx = 0;
      push(8'h00, 1'b0, 1'b0, tag);
      @(negedge clk); #1;
      en_wr = 1'b0;
      push(8'h00, 1'b1, !msg, tag);
      while (!fin) begin
         @(negedge clk); #1;
         if (msg && j == 0) chk(buf_empty == 1'b0, "R11", "buf_empty at start", int'(buf_empty), 0);
         fetch_rdy = rdy_mask[j % 32];
         bus_err   = (j == err_step);
         bidx      = k;
         if (!msg && j == err_step) begin
            push(8'h00, 1'b0, 1'b0, tag); fin = 1;
         end else if (rem == 0) begin
            push(8'h00, 1'b0, msg, tag); fin = 1;
         end else if (fetch_rdy) begin
            push(bmem[k], 1'b0, !msg, tag); k++; rem--;
         end else begin
            push(8'h00, 1'b0, !msg, tag);
         end
         j++;
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         bus_err = 1'b0; fetch_rdy = 1'b1;
         push(8'h00, 1'b0, 1'b0, idle_tag);
      end
      if (!msg) begin
         @(negedge clk); #1;
         en_wr = 1'b1; en_wdata = 1'b0;
         push(8'h00, 1'b0, 1'b0, idle_tag);
         @(negedge clk); #1;
         en_wr = 1'b0;
         push(8'h00, 1'b0, 1'b0, idle_tag);
      end
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      nchk++; nfail++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) bmem[i] = {1'b1, 7'(i * 13 + 5)};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_data == 8'h00, "R1", "out_data", int'(out_data), 0);
      chk(side_a == 1'b0 && side_b == 1'b0, "R1", "side pins", int'({side_a, side_b}), 0);
      chk(irq == 1'b0 && buf_empty == 1'b0 && enable_o == 1'b0, "R1", "flags",
          int'({irq, buf_empty, enable_o}), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_data == 8'h00 && side_a == 1'b0 && side_b == 1'b0, "R1", "after release",
          int'({side_a, side_b, out_data}), 0);

      sync_en = 1'b1;
      run_buf(1'b0, 6, 32'hFFFF_FFFF, -1, "R3/R4/R5", "R7");
      run_buf(1'b0, 5, 32'hFFFF_FF6D, -1, "R4/R13", "R7");
      run_buf(1'b0, 8, 32'hFFFF_FFFF, 3, "R6", "R6");
      run_buf(1'b0, 4, 32'hFFFF_FFFF, 0, "R6", "R6");
      run_buf(1'b0, 0, 32'hFFFF_FFFF, -1, "R12", "R7");

      // R2: no streaming without the sync bit
      @(negedge clk); #1;
      sync_en = 1'b0; mode_msg = 1'b0; en_wr = 1'b1; en_wdata = 1'b1; byte_count = 16'd4;
      push(8'h00, 1'b0, 1'b0, "R2");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); #1;
         en_wr = 1'b0;
         push(8'h00, 1'b0, 1'b0, "R2");
      end
      @(negedge clk); #1;
      en_wr = 1'b1; en_wdata = 1'b0;
      push(8'h00, 1'b0, 1'b0, "R2");
      @(negedge clk); #1;
      en_wr = 1'b0;
      wait (q.size() == 0);
      @(negedge clk);

      // message mode, sync low and a bus error pulse that must be ignored
      run_buf(1'b1, 5, 32'hFFFF_FFFF, 2, "R8/R9", "R10");
      chk(irq == 1'b1, "R9", "irq after end", int'(irq), 1);
      chk(buf_empty == 1'b1, "R9", "buf_empty after end", int'(buf_empty), 1);
      chk(enable_o == 1'b0, "R9", "enable self-clear", int'(enable_o), 0);
      repeat (3) @(negedge clk);
      chk(irq == 1'b1, "R11", "irq held", int'(irq), 1);
      #1 irq_ack = 1'b1;
      @(negedge clk); #1;
      irq_ack = 1'b0;
      chk(irq == 1'b0, "R11", "irq after ack", int'(irq), 0);
      chk(buf_empty == 1'b1, "R11", "buf_empty kept until next start", int'(buf_empty), 1);

      run_buf(1'b1, 0, 32'hFFFF_FFFF, -1, "R12", "R10");
      chk(irq == 1'b1 && buf_empty == 1'b1, "R12", "flags after empty message",
          int'({irq, buf_empty}), 3);
      #1 irq_ack = 1'b1;
      @(negedge clk); #1;
      irq_ack = 1'b0;
      run_buf(1'b1, 4, 32'hFFFF_FFF5, -1, "R4/R8", "R10");
      chk(enable_o == 1'b0, "R10", "enable stays clear", int'(enable_o), 0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule